// File: doc/BRIEF.md
# Capture/compare timer with handshake-cleared status flags

This block is one timer channel. It has a 16-bit counter that advances on every clock, and eight general registers, A to H. A mode input chooses, for each general register, whether it captures or compares. In capture mode, a rising edge on that register's capture input copies the counter into the register. In compare mode, the register raises an event when the counter reaches its value. Each event, and each wrap of the counter, sets a bit in a 16-bit status word. A masked OR of the status bits drives one interrupt request line.

Software clears a status bit with a two-step handshake. It first reads the status word while the bit is 1, and then writes 0 to that bit. A bit that was not seen set by such a read cannot be cleared. This prevents a flag that was raised between the read and the write from being lost. Software accesses the block over a plain synchronous bus: an address, a read strobe, a write strobe, and write and read data. Read data is registered.

Register addresses are as follows. Address 0 is the counter, which can be read and loaded. Address 1 is the status word. Address 2 is the interrupt enable word. Addresses 8 to 15 are general registers A to H. Every other address reads as 0.

Top module: `tmr_capcmp_status`

## Requirements
- R1: After reset, all status flags, the enable word, all general registers and the read data are 0, and the interrupt request is low.
- R2: Status bit 8 is the overflow flag, and bits 7 down to 0 are the event flags of general registers H down to A (bit 0 = A). Bits 15 to 9 always read 0, and writes to them are ignored.
- R3: The counter increments by one on every clock edge unless address 0 is written, in which case it loads the write data. The overflow flag sets on the edge where the counter steps from 0xFFFF to 0x0000.
- R4: In capture mode (mode bit 0), the capture input passes through two synchroniser flops and is then edge-detected. On the third clock edge after the input is first sampled high, the general register takes the counter value present before that edge, and its flag sets.
- R5: In compare mode (mode bit 1), a register's flag sets on the clock edge at which the counter equals that register.
- R6: A bus write to a general register raises no event for that register in the write cycle, in either mode.
- R7: A capture edge changes neither the register nor the flag of a general register in compare mode. A counter match sets no flag for a general register in capture mode.
- R8: Writing 1 to a status bit never sets it. Writing 0 to a set flag that has not been read as 1 since the last bus write leaves it at 1.
- R9: Reading the status word arms each flag that reads 1. A following status write with 0 in an armed bit clears that bit, and bits written 1 stay as they are. A read that returns 0 for a bit does not arm it.
- R10: Every bus write, to any address, disarms all flags. After any write, clearing a flag needs a new read.
- R11: If a flag's set condition and a valid clear fall in the same cycle, the flag stays 1.
- R12: The interrupt request is the OR of each flag ANDed with the enable bit at the same position of the enable word (address 2). It follows the flags and the enables in the same cycle that they change. Enable bits 15 to 9 read 0.
- R13: A read returns its data on the clock edge at which the read strobe is sampled, with the value held before that edge. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Register address |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| cap_i | input | 8 | Asynchronous capture inputs, bit 0 = register A |
| mode_i | input | 8 | Per-register mode, 0 = capture, 1 = compare |
| irq_o | output | 1 | Interrupt request |

## Verification
Read data is due on the edge that samples the read strobe. A flag and the interrupt line change on the same edge as the event that causes them. A compare flag appears on the edge where the counter equals the register. The overflow flag appears on the edge that leaves 0xFFFF. A capture lands on the third edge after its input is first sampled high. The bench places the counter at a known value with a bus write, counts edges from that write, and reads the interrupt line on the falling edges just before and just after the edge where each result is due. The set-wins case is lined up so that a compare match falls on exactly the edge of the clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   // Bus map of the channel
   localparam int unsigned REG_CNT     = 0;
   localparam int unsigned REG_STAT    = 1;
   localparam int unsigned REG_IEN     = 2;
   localparam int unsigned REG_GR_BASE = 8;

   typedef enum logic {
      GR_CAPTURE = 1'b0,
      GR_COMPARE = 1'b1
   } gr_mode_e;

endpackage

// File: rtl/tmr_free_counter.sv
module tmr_free_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic [W-1:0] cnt_o,
   output logic         wrap_o
);

   generate
      if (W < 2) begin : g_bad_w
         $error("tmr_free_counter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o  = cnt_q;
   // a wrap happens only when the all-ones value steps on by itself
   assign wrap_o = (&cnt_q) & ~load_i;

endmodule

// File: rtl/tmr_cap_sync.sv
module tmr_cap_sync #(
   parameter int unsigned N      = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] async_i,
   output logic [N-1:0] rise_o
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("tmr_cap_sync: STAGES must be at least 2");
      end
      if (N < 1) begin : g_bad_n
         $error("tmr_cap_sync: N must be at least 1");
      end
   endgenerate

   genvar ch;
   generate
      for (ch = 0; ch < N; ch++) begin : g_ch
         // pipe[STAGES-1:0] synchronise, pipe[STAGES] holds the previous level
         logic [STAGES:0] pipe;

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               pipe <= '0;
            end else begin
               pipe <= {pipe[STAGES-1:0], async_i[ch]};
            end
         end

         assign rise_o[ch] = pipe[STAGES-1] & ~pipe[STAGES];
      end
   endgenerate

endmodule

// File: rtl/tmr_gr_slot.sv
module tmr_gr_slot #(
   parameter int unsigned W = 16
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         compare_i,
   input  logic [W-1:0] cnt_i,
   input  logic         wr_i,
   input  logic [W-1:0] wdata_i,
   input  logic         cap_rise_i,
   output logic [W-1:0] gr_o,
   output logic         event_o
);

   import tmr_pkg::*;

   gr_mode_e     mode;
   logic [W-1:0] gr_q;
   logic         hit;
   logic         take_capture;

   assign mode = gr_mode_e'(compare_i);
   assign hit  = (cnt_i == gr_q);

   // a bus write owns the slot for its cycle: no capture, no event
   assign take_capture = (mode == GR_CAPTURE) && cap_rise_i && !wr_i;

   always_comb begin
      event_o = 1'b0;
      if (!wr_i) begin
         if (mode == GR_COMPARE) begin
            event_o = hit;
         end else begin
            event_o = cap_rise_i;
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         gr_q <= '0;
      end else if (wr_i) begin
         gr_q <= wdata_i;
      end else if (take_capture) begin
         gr_q <= cnt_i;
      end
   end

   assign gr_o = gr_q;

endmodule

// File: rtl/tmr_flag_bank.sv
module tmr_flag_bank #(
   parameter int unsigned N = 9
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic [N-1:0] set_i,
   input  logic         rd_arm_i,
   input  logic         wr_any_i,
   input  logic         wr_clr_i,
   input  logic [N-1:0] wdata_i,
   output logic [N-1:0] flags_o,
   output logic [N-1:0] arm_o
);

   generate
      if (N < 1) begin : g_bad_n
         $error("tmr_flag_bank: N must be at least 1");
      end
   endgenerate

   logic [N-1:0] flags_q;
   logic [N-1:0] arm_q;

   genvar b;
   generate
      for (b = 0; b < N; b++) begin : g_bit
         logic clr;
         assign clr = wr_clr_i & ~wdata_i[b] & arm_q[b];

         always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
               flags_q[b] <= 1'b0;
               arm_q[b]   <= 1'b0;
            end else begin
               // a new event outranks a clear in the same cycle
               if (set_i[b]) begin
                  flags_q[b] <= 1'b1;
               end else if (clr) begin
                  flags_q[b] <= 1'b0;
               end

               if (wr_any_i) begin
                  arm_q[b] <= 1'b0;
               end else if (rd_arm_i && flags_q[b]) begin
                  arm_q[b] <= 1'b1;
               end
            end
         end
      end
   endgenerate

   assign flags_o = flags_q;
   assign arm_o   = arm_q;

endmodule

// File: rtl/tmr_capcmp_status.sv
module tmr_capcmp_status
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W      = 16,
   parameter int unsigned NUM_GR      = 8,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              rd_i,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [NUM_GR-1:0] cap_i,
   input  logic [NUM_GR-1:0] mode_i,
   output logic              irq_o
);

   localparam int unsigned NUM_FLAGS = NUM_GR + 1;
   localparam int unsigned OVF_BIT   = NUM_GR;
   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);
   localparam logic [ADDR_W-1:0] A_IEN  = ADDR_W'(REG_IEN);

   generate
      if (NUM_GR < 1) begin : g_bad_gr
         $error("tmr_capcmp_status: NUM_GR must be at least 1");
      end
      if (NUM_FLAGS > DATA_W) begin : g_bad_flags
         $error("tmr_capcmp_status: flags do not fit the data width");
      end
      if (REG_GR_BASE + NUM_GR > (1 << ADDR_W)) begin : g_bad_map
         $error("tmr_capcmp_status: general registers exceed the address space");
      end
   endgenerate

   // address decode
   logic              sel_cnt;
   logic              sel_stat;
   logic              sel_ien;
   logic [NUM_GR-1:0] sel_gr;

   assign sel_cnt  = (addr_i == A_CNT);
   assign sel_stat = (addr_i == A_STAT);
   assign sel_ien  = (addr_i == A_IEN);

   genvar gi;
   generate
      for (gi = 0; gi < NUM_GR; gi++) begin : g_dec
         assign sel_gr[gi] = (addr_i == ADDR_W'(REG_GR_BASE + gi));
      end
   endgenerate

   // counter
   logic [DATA_W-1:0] cnt;
   logic              wrap;

   tmr_free_counter #(
      .W (DATA_W)
   ) u_cnt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .load_i     (wr_i && sel_cnt),
      .load_val_i (wdata_i),
      .cnt_o      (cnt),
      .wrap_o     (wrap)
   );

   // capture input synchronisers
   logic [NUM_GR-1:0] cap_rise;

   tmr_cap_sync #(
      .N      (NUM_GR),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (cap_i),
      .rise_o  (cap_rise)
   );

   // general register slots
   logic [DATA_W-1:0]    gr_val [NUM_GR];
   logic [NUM_FLAGS-1:0] set_vec;

   generate
      for (gi = 0; gi < NUM_GR; gi++) begin : g_slot
         tmr_gr_slot #(
            .W (DATA_W)
         ) u_slot (
            .clk_i      (clk_i),
            .rst_ni     (rst_ni),
            .compare_i  (mode_i[gi]),
            .cnt_i      (cnt),
            .wr_i       (wr_i && sel_gr[gi]),
            .wdata_i    (wdata_i),
            .cap_rise_i (cap_rise[gi]),
            .gr_o       (gr_val[gi]),
            .event_o    (set_vec[gi])
         );
      end
   endgenerate

   assign set_vec[OVF_BIT] = wrap;

   // status flags
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] arm;

   tmr_flag_bank #(
      .N (NUM_FLAGS)
   ) u_flags (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_vec),
      .rd_arm_i (rd_i && sel_stat),
      .wr_any_i (wr_i),
      .wr_clr_i (wr_i && sel_stat),
      .wdata_i  (wdata_i[NUM_FLAGS-1:0]),
      .flags_o  (flags),
      .arm_o    (arm)
   );

   // interrupt enables
   logic [NUM_FLAGS-1:0] ien_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ien_q <= '0;
      end else if (wr_i && sel_ien) begin
         ien_q <= wdata_i[NUM_FLAGS-1:0];
      end
   end

   assign irq_o = |(flags & ien_q);

   // read path
   logic [DATA_W-1:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (sel_cnt) begin
         rd_val = cnt;
      end
      if (sel_stat) begin
         rd_val[NUM_FLAGS-1:0] = flags;
      end
      if (sel_ien) begin
         rd_val[NUM_FLAGS-1:0] = ien_q;
      end
      for (int i = 0; i < NUM_GR; i++) begin
         if (sel_gr[i]) begin
            rd_val = gr_val[i];
         end
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         rdata_o <= '0;
      end else if (rd_i) begin
         rdata_o <= rd_val;
      end
   end

endmodule

// File: rtl/tmr_capcmp_status_chk.sv
module tmr_capcmp_status_chk
   import tmr_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned NUM_GR = 8,
   parameter int unsigned ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [ADDR_W-1:0] addr_i,
   input logic              rd_i,
   input logic              wr_i,
   input logic [DATA_W-1:0] wdata_i,
   input logic [DATA_W-1:0] rdata_o,
   input logic              irq_o,
   input logic [NUM_GR:0]   flags_i,
   input logic [NUM_GR:0]   arm_i,
   input logic [NUM_GR:0]   set_i,
   input logic [DATA_W-1:0] cnt_i
);

   localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(REG_CNT);
   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(REG_STAT);

   // R3
   overflow_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((cnt_i == '1) && !(wr_i && addr_i == A_CNT)) |=> flags_i[NUM_GR]);

   // R10
   write_disarms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $past(wr_i) |-> (arm_i == '0));

   // R12
   irq_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (flags_i != '0));

   generate
      if (DATA_W > NUM_GR + 1) begin : g_resv
         // R2
         reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rd_i && addr_i == A_STAT) |-> (rdata_o[DATA_W-1:NUM_GR+1] == '0));
      end
   endgenerate

   genvar b;
   generate
      for (b = 0; b <= NUM_GR; b++) begin : g_bit
         // R9
         flag_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $fell(flags_i[b]) |-> $past(wr_i && addr_i == A_STAT && !wdata_i[b] && arm_i[b]));

         // R8
         no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $rose(flags_i[b]) |-> $past(set_i[b]));

         // R9
         arm_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            arm_i[b] |-> flags_i[b]);

         // R11
         set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_i[b] |=> flags_i[b]);
      end

      for (b = 0; b < NUM_GR; b++) begin : g_gr
         // R6
         gr_write_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (wr_i && addr_i == ADDR_W'(REG_GR_BASE + b)) |-> !set_i[b]);
      end
   endgenerate

endmodule

bind tmr_capcmp_status tmr_capcmp_status_chk #(
   .DATA_W (DATA_W),
   .NUM_GR (NUM_GR),
   .ADDR_W (ADDR_W)
) i_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .addr_i  (addr_i),
   .rd_i    (rd_i),
   .wr_i    (wr_i),
   .wdata_i (wdata_i),
   .rdata_o (rdata_o),
   .irq_o   (irq_o),
   .flags_i (flags),
   .arm_i   (arm),
   .set_i   (set_vec),
   .cnt_i   (cnt)
);

// File: tb/test_tmr_capcmp_status.sv
`timescale 1ns/1ps
module test_tmr_capcmp_status;

   localparam logic [3:0] A_CNT  = 4'd0;
   localparam logic [3:0] A_STAT = 4'd1;
   localparam logic [3:0] A_IEN  = 4'd2;
   localparam logic [3:0] A_GR   = 4'd8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  addr = '0;
   logic        rd = 1'b0;
   logic        wr = 1'b0;
   logic [15:0] wdata = '0;
   logic [15:0] rdata;
   logic [7:0]  cap = '0;
   logic [7:0]  mode = '0;
   logic        irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tmr_capcmp_status i_tmr_capcmp_status (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .addr_i  (addr),
      .rd_i    (rd),
      .wr_i    (wr),
      .wdata_i (wdata),
      .rdata_o (rdata),
      .cap_i   (cap),
      .mode_i  (mode),
      .irq_o   (irq)
   );

   task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all bus tasks start and end on a falling edge
   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
      addr = a; rd = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd = 1'b0;
      d = rdata;
   endtask

   task automatic clear_all();
      logic [15:0] d;
      bus_rd(A_STAT, d);
      bus_wr(A_STAT, 16'h0000);
   endtask

   task automatic pulse_cap(input int idx);
      cap[idx] = 1'b1;
      repeat (4) @(negedge clk);
      cap[idx] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] d;
      chk("R1 irq after reset", {15'b0, irq}, 16'h0000);
      chk("R1 rdata after reset", rdata, 16'h0000);
      bus_rd(A_STAT, d);  chk("R1 status after reset", d, 16'h0000);
      bus_rd(A_IEN, d);   chk("R1 enable after reset", d, 16'h0000);
      for (int i = 0; i < 8; i++) begin
         bus_rd(A_GR + 4'(i), d);
         chk("R1 general register after reset", d, 16'h0000);
      end
   endtask

   task automatic t_unmapped();
      logic [15:0] d;
      bus_rd(4'd5, d);  chk("R13 unmapped address 5", d, 16'h0000);
      bus_rd(4'd3, d);  chk("R13 unmapped address 3", d, 16'h0000);
   endtask

   task automatic t_overflow();
      logic [15:0] d;
      bus_wr(A_CNT, 16'hFFF0);
      bus_rd(A_CNT, d);   chk("R13 R3 counter read after load", d, 16'hFFF0);
      bus_rd(A_STAT, d);  chk("R3 no overflow before wrap", d, 16'h0000);
      bus_wr(A_IEN, 16'h0100);
      bus_wr(A_CNT, 16'hFFFD);
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R3 overflow not yet set at 0xFFFF", {15'b0, irq}, 16'h0000);
      @(posedge clk); @(negedge clk);
      chk("R3 overflow set on wrap edge", {15'b0, irq}, 16'h0001);
      bus_rd(A_CNT, d);   chk("R3 counter after wrap", d, 16'h0000);
      bus_rd(A_STAT, d);  chk("R2 overflow in bit 8", d, 16'h0100);
      clear_all();
      bus_wr(A_IEN, 16'h0000);
      bus_wr(A_CNT, 16'h0100);
   endtask

   task automatic t_capture();
      logic [15:0] d;
      bus_wr(A_IEN, 16'h0001);
      bus_wr(A_CNT, 16'h1230);
      cap[0] = 1'b1;
      @(posedge clk); @(posedge clk); @(negedge clk);
      chk("R4 capture flag not before third edge", {15'b0, irq}, 16'h0000);
      @(posedge clk); @(negedge clk);
      chk("R4 capture flag on third edge", {15'b0, irq}, 16'h0001);
      cap[0] = 1'b0;
      bus_rd(A_GR, d);    chk("R4 captured counter value", d, 16'h1232);
      bus_rd(A_STAT, d);  chk("R2 register A flag in bit 0", d, 16'h0001);
      bus_wr(A_STAT, 16'h0000);
      bus_wr(A_IEN, 16'h0000);
   endtask

   task automatic t_compare();
      logic [15:0] d;
      mode[3] = 1'b1;
      bus_wr(A_GR + 4'd3, 16'h7305);
      bus_wr(A_IEN, 16'h0008);
      bus_wr(A_CNT, 16'h7300);
      repeat (5) @(posedge clk);
      @(negedge clk);
      chk("R5 compare flag not before match edge", {15'b0, irq}, 16'h0000);
      @(posedge clk); @(negedge clk);
      chk("R5 compare flag on match edge", {15'b0, irq}, 16'h0001);
      bus_rd(A_STAT, d);  chk("R2 register D flag in bit 3", d, 16'h0008);
      bus_wr(A_STAT, 16'h0000);
      bus_wr(A_IEN, 16'h0000);
      mode[3] = 1'b0;
   endtask

   task automatic t_cmp_write();
      logic [15:0] d;
      mode[4] = 1'b1;
      bus_wr(A_CNT, 16'h1000);
      bus_wr(A_GR + 4'd4, 16'h1000);
      repeat (3) @(negedge clk);
      bus_rd(A_STAT, d);  chk("R6 compare write raises no event", d, 16'h0000);
      bus_rd(A_GR + 4'd4, d);  chk("R6 compare register written", d, 16'h1000);
      mode[4] = 1'b0;
   endtask

   task automatic t_mode_ignore();
      logic [15:0] d;
      mode[1] = 1'b1;
      bus_wr(A_GR + 4'd1, 16'hAAAA);
      pulse_cap(1);
      bus_rd(A_GR + 4'd1, d);  chk("R7 capture ignored in compare mode", d, 16'hAAAA);
      bus_rd(A_STAT, d);       chk("R7 no flag from capture in compare mode", d, 16'h0000);
      mode[1] = 1'b0;
      bus_wr(A_CNT, 16'h0200);
      bus_wr(A_GR + 4'd2, 16'h0208);
      repeat (20) @(negedge clk);
      bus_rd(A_STAT, d);       chk("R7 no flag from match in capture mode", d, 16'h0000);
      bus_rd(A_GR + 4'd2, d);  chk("R7 capture register unchanged by match", d, 16'h0208);
   endtask

   task automatic t_clear_protocol();
      logic [15:0] d;
      clear_all();
      pulse_cap(0);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R8 write 0 without read keeps flag", d, 16'h0001);
      bus_wr(A_STAT, 16'hFFFF);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R10 write of 1 disarms, later 0 keeps flag", d, 16'h0001);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R9 read then write 0 clears", d, 16'h0000);
      bus_wr(A_STAT, 16'hFFFF);
      bus_rd(A_STAT, d);  chk("R8 R2 writing ones sets nothing", d, 16'h0000);
      pulse_cap(0);
      pulse_cap(2);
      bus_rd(A_STAT, d);  chk("R9 two flags set", d, 16'h0005);
      bus_wr(A_STAT, 16'hFFFE);
      bus_rd(A_STAT, d);  chk("R9 only the bit written 0 clears", d, 16'h0004);
      bus_wr(A_STAT, 16'h0000);
   endtask

   task automatic t_arm_needs_one();
      logic [15:0] d;
      clear_all();
      bus_rd(A_STAT, d);  chk("R9 flags clear before arming test", d, 16'h0000);
      pulse_cap(2);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R9 read of 0 does not arm", d, 16'h0004);
      bus_wr(A_STAT, 16'h0000);
   endtask

   task automatic t_set_wins();
      logic [15:0] d;
      clear_all();
      mode[1] = 1'b1;
      bus_wr(A_GR + 4'd1, 16'h5001);
      bus_wr(A_CNT, 16'h4FF0);
      repeat (30) @(negedge clk);
      bus_wr(A_CNT, 16'h5000);
      bus_rd(A_STAT, d);  chk("R11 flag B set before collision", d, 16'h0002);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R11 set wins over clear", d, 16'h0002);
      bus_wr(A_STAT, 16'h0000);
      bus_rd(A_STAT, d);  chk("R11 later clear succeeds", d, 16'h0000);
      mode[1] = 1'b0;
   endtask

   task automatic t_irq();
      logic [15:0] d;
      clear_all();
      bus_wr(A_IEN, 16'h0000);
      pulse_cap(0);
      chk("R12 irq masked", {15'b0, irq}, 16'h0000);
      bus_wr(A_IEN, 16'h0001);
      chk("R12 irq enabled", {15'b0, irq}, 16'h0001);
      bus_wr(A_IEN, 16'h0002);
      chk("R12 other enable only", {15'b0, irq}, 16'h0000);
      bus_wr(A_IEN, 16'hFFFF);
      bus_rd(A_IEN, d);  chk("R12 enable reserved bits read 0", d, 16'h01FF);
      bus_wr(A_IEN, 16'h0000);
      clear_all();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_unmapped();
      t_overflow();
      t_capture();
      t_compare();
      t_cmp_write();
      t_mode_ignore();
      t_clear_protocol();
      t_arm_needs_one();
      t_set_wins();
      t_irq();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog all requirements actual=timeout expected=done");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule